// File: doc/BRIEF.md
# Extended Bank-Select CAS Steering

This block sits next to the memory management unit of an 8-bit system. That unit honours only one of the two bank-select bits in its configuration registers. This block restores the dropped bit. It keeps a write-only shadow copy of the bank field of every configuration register. The copy loads on the same CPU writes that reach the primary unit, at the same register addresses, so no new I/O location appears. The two upper data bits are exchanged on the way into the shadow copy, matching how the second controller sees them on the board. They are exchanged back at the decoder, so software sees the ordinary bank numbering and existing bank commands and OS calls reach banks 2 and 3 unchanged.

The live configuration index picks which shadow entry drives the bank decode. The decoded bank then gates the raw video-controller column strobe onto one of four active-low per-bank CAS lines, and only while the address decoder's CAS-enable is active. Every bank is built from 64Kx4 parts, so choosing the CAS line is the whole bank selection; no extra multiplexed address bit is made. An external force input limits the block to two banks, for software that moves the zero page or stack.

Top module: `xbank_cas_steer`

## Requirements
- R1: After reset every shadow entry holds bank 0, so the first strobed access on any live index pulls only `bank_cas_n[0]` low.
- R2: A clock edge with `reg_sel_n`=0 and `rd_wr`=0 stores the bank number {`cpu_data[7]`,`cpu_data[6]`} (bit 7 is the high bank bit) into the entry addressed by `reg_idx`.
- R3: A clock edge with `rd_wr`=1, or with `reg_sel_n`=1, leaves every shadow entry unchanged.
- R4: `bank_cas_n[b]` is low in the same cycle exactly when `vid_cas_n`=0, `cas_en_n`=0 and the selected bank equals b. The output is combinational from the stored state and these inputs.
- R5: At most one `bank_cas_n` bit is low at any time.
- R6: While `cas_en_n`=1, all four `bank_cas_n` lines stay high whatever the strobe and bank are.
- R7: While `force_two_bank`=1, the high bank bit is treated as 0, so bank 2 steers to line 0 and bank 3 to line 1. The stored entry is kept, and clearing the input restores bank 2 or 3.
- R8: The bank comes from the entry addressed by `live_idx`; writes to other entries do not change it.
- R9: Data bits 5 to 0 of a write have no effect on the selected bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears the shadow entries |
| cpu_data | input | 8 | CPU data bus |
| reg_sel_n | input | 1 | Active-low register access enable from the combined upper register-address lines |
| rd_wr | input | 1 | 1 = read cycle, 0 = write cycle |
| reg_idx | input | 2 | Configuration register index of the current access |
| live_idx | input | 2 | Index of the configuration register now in force |
| cas_en_n | input | 1 | Active-low CAS enable from the address decode logic |
| vid_cas_n | input | 1 | Active-low raw column strobe from the video controller |
| force_two_bank | input | 1 | 1 = ignore the high bank bit (two-bank behaviour) |
| bank_cas_n | output | 4 | Active-low per-bank column strobes |

## Verification
A corrupted shadow entry does not show up until the next strobed access that uses its index. That access then fires the wrong CAS line in the same cycle, so every write is followed at once by an access on the written index. A bit-order mistake in the exchange or restore path swaps banks 1 and 2 while leaving 0 and 3 correct, so all four bank values are written. A read that disturbs the state only shows on a later access, so accesses are made after read cycles and after deselected writes, using data that would select a different bank.

// File: rtl/xbank_pkg.sv
package xbank_pkg;
  localparam int BANKS  = 4;
  localparam int BANK_W = 2;

  typedef logic [BANK_W-1:0] bank_t;

  // exchange the two bits of a bank field, as the write path presents them
  function automatic logic [BANK_W-1:0] swap_pair(input logic [BANK_W-1:0] f);
    return {f[0], f[1]};
  endfunction

  // restore ordinary bank numbering from a stored (exchanged) field
  function automatic bank_t restore_bank(input logic [BANK_W-1:0] stored);
    return bank_t'(swap_pair(stored));
  endfunction

  // two-bank limit drops the high bank bit
  function automatic bank_t limit_bank(input bank_t b, input logic two_only);
    return two_only ? {1'b0, b[0]} : b;
  endfunction
endpackage

// File: rtl/xbank_shadow.sv
module xbank_shadow
  import xbank_pkg::*;
#(
  parameter int NUM_REGS  = 4,
  parameter int DATA_W    = 8,
  parameter int FIELD_LSB = 6,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              reg_sel_n,
  input  logic              rd_wr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BANK_W-1:0] stored_field
);
  logic                wr_fire;
  logic [NUM_REGS-1:0] wr_hit;
  logic [BANK_W-1:0]   wr_field;
  logic [BANK_W-1:0]   entry [NUM_REGS];

  // write-only: only a selected write cycle loads; reads never drive anything
  assign wr_fire  = !reg_sel_n && !rd_wr;
  assign wr_field = swap_pair(wdata[FIELD_LSB +: BANK_W]);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    assign wr_hit[i] = wr_fire && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         entry[i] <= '0;
      else if (wr_hit[i]) entry[i] <= wr_field;
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> entry[i] == $past(wr_field)); // R2
    AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[i] |=> $stable(entry[i])); // R3
  end

  assign stored_field = entry[rd_idx];

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit)); // R2
endmodule

// File: rtl/xbank_decode.sv
module xbank_decode
  import xbank_pkg::*;
(
  input  logic [BANK_W-1:0] stored_field,
  input  logic              force_two_bank,
  output bank_t             bank,
  output logic [BANKS-1:0]  bank_sel
);
  assign bank = limit_bank(restore_bank(stored_field), force_two_bank);

  for (genvar b = 0; b < BANKS; b++) begin : g_sel
    assign bank_sel[b] = (bank == bank_t'(b));
  end

  always_comb begin
    if (force_two_bank) AST_TWO_BANK: assert (!bank_sel[2] && !bank_sel[3]); // R7
  end
endmodule

// File: rtl/xbank_cas_gate.sv
module xbank_cas_gate
  import xbank_pkg::*;
(
  input  logic [BANKS-1:0] bank_sel,
  input  logic             cas_en_n,
  input  logic             vid_cas_n,
  output logic [BANKS-1:0] cas_n
);
  logic strobe_live;

  assign strobe_live = !cas_en_n && !vid_cas_n;

  for (genvar b = 0; b < BANKS; b++) begin : g_line
    assign cas_n[b] = !(strobe_live && bank_sel[b]);
  end
endmodule

// File: rtl/xbank_cas_steer.sv
module xbank_cas_steer
  import xbank_pkg::*;
#(
  parameter int NUM_REGS  = 4,
  parameter int DATA_W    = 8,
  parameter int FIELD_LSB = 6,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              reg_sel_n,
  input  logic              rd_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [IDX_W-1:0]  live_idx,
  input  logic              cas_en_n,
  input  logic              vid_cas_n,
  input  logic              force_two_bank,
  output logic [BANKS-1:0]  bank_cas_n
);
  logic [BANK_W-1:0] live_field;
  bank_t             live_bank;
  logic [BANKS-1:0]  live_sel;

  xbank_shadow #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .FIELD_LSB(FIELD_LSB)
  ) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdata       (cpu_data),
    .reg_sel_n   (reg_sel_n),
    .rd_wr       (rd_wr),
    .wr_idx      (reg_idx),
    .rd_idx      (live_idx),
    .stored_field(live_field)
  );

  xbank_decode u_decode (
    .stored_field  (live_field),
    .force_two_bank(force_two_bank),
    .bank          (live_bank),
    .bank_sel      (live_sel)
  );

  xbank_cas_gate u_gate (
    .bank_sel (live_sel),
    .cas_en_n (cas_en_n),
    .vid_cas_n(vid_cas_n),
    .cas_n    (bank_cas_n)
  );

  AST_CAS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bank_cas_n)); // R5
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cas_en_n |-> &bank_cas_n); // R6
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    vid_cas_n |-> &bank_cas_n); // R4
  AST_LINE_MATCHES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_en_n && !vid_cas_n) |-> !bank_cas_n[live_bank]); // R4
endmodule

// File: tb/test_xbank_cas_steer.sv
module test_xbank_cas_steer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cpu_data = 8'h00;
  logic       reg_sel_n = 1'b1;
  logic       rd_wr = 1'b1;
  logic [1:0] reg_idx = 2'd0;
  logic [1:0] live_idx = 2'd0;
  logic       cas_en_n = 1'b1;
  logic       vid_cas_n = 1'b1;
  logic       force_two_bank = 1'b0;
  logic [3:0] bank_cas_n;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;
  int model [4];   // expected bank per register

  always #2.5 clk = ~clk;

  xbank_cas_steer i_xbank_cas_steer (
    .clk(clk), .rst_n(rst_n), .cpu_data(cpu_data), .reg_sel_n(reg_sel_n),
    .rd_wr(rd_wr), .reg_idx(reg_idx), .live_idx(live_idx), .cas_en_n(cas_en_n),
    .vid_cas_n(vid_cas_n), .force_two_bank(force_two_bank), .bank_cas_n(bank_cas_n)
  );

  function automatic logic [3:0] line_for(input int bank);
    logic [3:0] v = 4'b1111;
    v[bank] = 1'b0;
    return v;
  endfunction

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: bank_cas_n=%b expected %b", req, got, exp);
    end
  endtask

  task automatic cpu_cycle(input logic sel_n, input logic rw, input int idx, input logic [7:0] d);
    @(negedge clk);
    reg_sel_n = sel_n; rd_wr = rw; reg_idx = 2'(idx); cpu_data = d;
    @(negedge clk);
    reg_sel_n = 1'b1; rd_wr = 1'b1; cpu_data = 8'h00;
  endtask

  task automatic write_reg(input int idx, input logic [7:0] d);
    cpu_cycle(1'b0, 1'b0, idx, d);
    model[idx] = int'(d[7:6]);
  endtask

  // strobed access on live index; samples mid-cycle, then releases
  task automatic access(input string req, input int idx, input logic en_n,
                        input logic vcas_n, input logic [3:0] exp);
    @(negedge clk);
    live_idx = 2'(idx); cas_en_n = en_n; vid_cas_n = vcas_n;
    #1;
    check(req, bank_cas_n, exp);
    @(negedge clk);
    cas_en_n = 1'b1; vid_cas_n = 1'b1;
  endtask

  task automatic t_reset;
    check("R6 idle after reset", bank_cas_n, 4'b1111);
    for (int i = 0; i < 4; i++) access("R1 reset bank 0", i, 1'b0, 1'b0, 4'b1110);
  endtask

  task automatic t_all_banks;
    for (int b = 0; b < 4; b++) begin
      write_reg(0, 8'(b << 6));
      access("R2 bank value written", 0, 1'b0, 1'b0, line_for(b));
    end
  endtask

  task automatic t_low_bits;
    write_reg(1, 8'h3F);   // bank 0 despite low ones
    access("R9 low bits ignored", 1, 1'b0, 1'b0, line_for(0));
    write_reg(1, 8'h95);   // bank 2
    access("R9 low bits ignored bank 2", 1, 1'b0, 1'b0, line_for(2));
  endtask

  task automatic t_reads_and_deselect;
    write_reg(2, 8'h40);   // bank 1
    cpu_cycle(1'b0, 1'b1, 2, 8'hC0);   // read cycle with bank-3 data
    access("R3 read leaves entry", 2, 1'b0, 1'b0, line_for(model[2]));
    cpu_cycle(1'b1, 1'b0, 2, 8'h80);   // write without register enable
    access("R3 deselected write ignored", 2, 1'b0, 1'b0, line_for(model[2]));
  endtask

  task automatic t_gating;
    write_reg(3, 8'hC0);   // bank 3
    access("R6 cas enable off", 3, 1'b1, 1'b0, 4'b1111);
    access("R4 no video strobe", 3, 1'b0, 1'b1, 4'b1111);
    access("R4 strobe and enable", 3, 1'b0, 1'b0, line_for(3));
  endtask

  task automatic t_live_select;
    write_reg(0, 8'h80);
    write_reg(1, 8'h40);
    write_reg(2, 8'hC0);
    write_reg(3, 8'h00);
    for (int i = 0; i < 4; i++)
      access("R8 live index selects entry", i, 1'b0, 1'b0, line_for(model[i]));
    for (int i = 0; i < 4; i++) begin
      access("R5 single line low", i, 1'b0, 1'b0, line_for(model[i]));
    end
  endtask

  task automatic t_two_bank;
    force_two_bank = 1'b1;
    access("R7 bank 2 folds to 0", 0, 1'b0, 1'b0, line_for(0));
    access("R7 bank 3 folds to 1", 2, 1'b0, 1'b0, line_for(1));
    access("R7 bank 1 unchanged", 1, 1'b0, 1'b0, line_for(1));
    force_two_bank = 1'b0;
    access("R7 bank 2 restored", 0, 1'b0, 1'b0, line_for(2));
    access("R7 bank 3 restored", 2, 1'b0, 1'b0, line_for(3));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_banks();
    t_low_bits();
    t_reads_and_deselect();
    t_gating();
    t_live_select();
    t_two_bank();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule